// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles the control-flow outcome of one jump-family instruction for a 64-bit register machine. For each instruction it receives the opcode byte, the 4-bit source-register field, both operand values, an immediate that has already been sign-extended, a 16-bit signed displacement and the current program counter. It produces a taken flag and the next program counter, counted in 64-bit instruction slots. It also raises flags that mark a call, a return from the program or an illegal encoding. For calls it reports the call sub-type and the helper identifier. It does not run helpers and keeps no return stack.

Instructions enter over a valid/ready stream, and results leave over a second valid/ready stream. The block holds one result register between the two. It accepts a new instruction in any cycle where its output slot is empty or is being drained in that cycle. When the consumer holds `out_ready` low while `out_valid` is high, the result stays frozen and `in_ready` drops. A result appears one clock after its instruction is accepted.

Top module: `brn_resolve`

## Requirements
- R1: While reset is active and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and its result is presented with `out_valid` = 1 after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, every result output holds its value.
- R3: The class is `in_opcode[2:0]`. Class 5 compares the full 64-bit operands. Class 6 compares only bits 31:0, and for signed compares it takes bit 31 as the sign.
- R4: `in_opcode[3]` picks the second operand: 0 selects `in_imm` and 1 selects `in_src_val`. The first operand is always `in_dst_val`. The condition code is `in_opcode[7:4]`.
- R5: The unsigned conditions are greater-than (2), greater-or-equal (3), less-than (0xa) and less-or-equal (0xb).
- R6: The signed two's-complement conditions are greater-than (6), greater-or-equal (7), less-than (0xc) and less-or-equal (0xd).
- R7: Code 1 is taken on equal operands and code 5 on unequal operands. Code 4 is taken when the bitwise AND of the two operands is non-zero.
- R8: When taken, `out_next_pc` = `in_pc` + 1 + sign-extended `in_offset`. Otherwise it is `in_pc` + 1. Both sums wrap modulo 2^32.
- R9: Code 0 in class 5 is an unconditional jump and is always taken. Opcode bit 3 has no effect on it.
- R10: Code 9 in class 5 is a program exit. It sets `out_is_exit` = 1 and `out_taken` = 0, and the next PC is `in_pc` + 1.
- R11: Code 8 in class 5 is a call. It sets `out_is_call` = 1, and `out_call_kind` carries `in_src_field[1:0]`. Sub-type 1 is a local call and is taken to `in_pc` + 1 + offset. Sub-types 0 (helper by address) and 2 (helper by type ID) are not taken, and `out_helper_id` = `in_imm[31:0]`. Any sub-type above 2 is illegal.
- R12: Any of the following sets `out_illegal` = 1, with `out_taken`, `out_is_call` and `out_is_exit` all 0 and the next PC `in_pc` + 1:
  - a class other than 5 or 6;
  - code 0xe or 0xf;
  - code 0, 8 or 9 in class 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block can take an instruction |
| in_opcode | input | 8 | Opcode byte: condition code, operand select, class |
| in_src_field | input | 4 | Source-register field, which carries the call sub-type |
| in_dst_val | input | 64 | First operand |
| in_src_val | input | 64 | Register second operand |
| in_imm | input | 64 | Sign-extended immediate second operand |
| in_offset | input | 16 | Signed displacement in instruction slots |
| in_pc | input | 32 | Current program counter in slots |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_taken | output | 1 | Control transfers to the displaced target |
| out_next_pc | output | 32 | Next program counter |
| out_is_call | output | 1 | Instruction is a call |
| out_call_kind | output | 2 | Call sub-type |
| out_helper_id | output | 32 | Helper identifier for calls |
| out_is_exit | output | 1 | Instruction is a program exit |
| out_illegal | output | 1 | Encoding is not allowed |

## Verification
The bench feeds operands that agree in their low 32 bits but differ above them. A resolver that ignores the class width then gives the wrong outcome for one of the two classes. It also uses pairs where the signed and unsigned orderings disagree, such as all-ones against one, so a resolver that swaps signedness inverts those results. The bench checks PC wrap at the top of the range and negative displacements back to zero, which exposes a missing sign extension or a missing +1. It sweeps every opcode byte, so an unconditional jump, call or exit in the 32-bit class that slips through without the illegal flag is caught. Random back-pressure shows whether a result changes, or is lost, while the consumer stalls.

// File: rtl/brn_pkg.sv
package brn_pkg;
  localparam logic [2:0] CLS_WIDE   = 3'd5;
  localparam logic [2:0] CLS_NARROW = 3'd6;

  typedef enum logic [3:0] {
    C_JA   = 4'h0, C_EQ   = 4'h1, C_GTU  = 4'h2, C_GEU = 4'h3,
    C_SET  = 4'h4, C_NE   = 4'h5, C_GTS  = 4'h6, C_GES = 4'h7,
    C_CALL = 4'h8, C_EXIT = 4'h9, C_LTU  = 4'ha, C_LEU = 4'hb,
    C_LTS  = 4'hc, C_LES  = 4'hd, C_RSV0 = 4'he, C_RSV1 = 4'hf
  } cond_e;

  localparam logic [1:0] CALL_HELPER_ADDR = 2'd0;
  localparam logic [1:0] CALL_LOCAL       = 2'd1;
  localparam logic [1:0] CALL_HELPER_TID  = 2'd2;

  typedef struct packed {
    logic       is_cond;
    logic       is_ja;
    logic       is_call;
    logic       is_exit;
    logic       illegal;
    logic       use_reg;
    logic       narrow;
    logic [1:0] call_kind;
    cond_e      code;
  } brn_dec_t;
endpackage

// File: rtl/brn_decode.sv
module brn_decode
  import brn_pkg::*;
#(
  parameter int OP_W  = 8,
  parameter int FLD_W = 4
) (
  input  logic [OP_W-1:0]  opcode,
  input  logic [FLD_W-1:0] src_field,
  output brn_dec_t         dec
);
  localparam int CODE_LSB = OP_W - 4;

  logic [2:0] cls;
  cond_e      code;
  logic       cls_ok;
  logic       narrow;
  logic       kind_ok;

  assign cls     = opcode[2:0];
  assign code    = cond_e'(opcode[OP_W-1:CODE_LSB]);
  assign cls_ok  = (cls == CLS_WIDE) || (cls == CLS_NARROW);
  assign narrow  = (cls == CLS_NARROW);
  assign kind_ok = (src_field <= FLD_W'(CALL_HELPER_TID));

  always_comb begin
    dec           = '0;
    dec.code      = code;
    dec.use_reg   = opcode[3];
    dec.narrow    = narrow;
    dec.call_kind = src_field[1:0];
    if (!cls_ok) begin
      dec.illegal = 1'b1;
    end else begin
      unique case (code)
        C_JA: begin
          dec.is_ja   = !narrow;
          dec.illegal = narrow;
        end
        C_CALL: begin
          dec.is_call = !narrow && kind_ok;
          dec.illegal = narrow || !kind_ok;
        end
        C_EXIT: begin
          dec.is_exit = !narrow;
          dec.illegal = narrow;
        end
        C_RSV0, C_RSV1: dec.illegal = 1'b1;
        default:        dec.is_cond = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/brn_cond_eval.sv
module brn_cond_eval
  import brn_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic            narrow,
  input  cond_e           code,
  output logic            hit
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] a_u, b_u, a_s, b_s;
  logic            eq, lt_u, lt_s, any_bit;

  // Narrow class: unsigned view zero-extends the low half, signed view sign-extends it.
  generate
    if (HALF > 0) begin : g_views
      always_comb begin
        if (narrow) begin
          a_u = {{(XLEN-HALF){1'b0}}, opa[HALF-1:0]};
          b_u = {{(XLEN-HALF){1'b0}}, opb[HALF-1:0]};
          a_s = {{(XLEN-HALF){opa[HALF-1]}}, opa[HALF-1:0]};
          b_s = {{(XLEN-HALF){opb[HALF-1]}}, opb[HALF-1:0]};
        end else begin
          a_u = opa;
          b_u = opb;
          a_s = opa;
          b_s = opb;
        end
      end
    end
  endgenerate

  assign eq      = (a_u == b_u);
  assign lt_u    = (a_u < b_u);
  assign lt_s    = ($signed(a_s) < $signed(b_s));
  assign any_bit = |(a_u & b_u);

  always_comb begin
    unique case (code)
      C_EQ:    hit = eq;
      C_NE:    hit = !eq;
      C_SET:   hit = any_bit;
      C_GTU:   hit = !lt_u && !eq;
      C_GEU:   hit = !lt_u;
      C_LTU:   hit = lt_u;
      C_LEU:   hit = lt_u || eq;
      C_GTS:   hit = !lt_s && !eq;
      C_GES:   hit = !lt_s;
      C_LTS:   hit = lt_s;
      C_LES:   hit = lt_s || eq;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/brn_target.sv
module brn_target #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  input  logic             taken,
  output logic [PC_W-1:0]  next_pc
);
  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] disp;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp = {{EXT_W{offset[OFF_W-1]}}, offset};
    end else begin : g_trunc
      assign disp = offset[PC_W-1:0];
    end
  endgenerate

  assign seq_pc  = pc + PC_W'(1);
  assign next_pc = taken ? (seq_pc + disp) : seq_pc;
endmodule

// File: rtl/brn_resolve.sv
module brn_resolve
  import brn_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int PC_W  = 32,
  parameter int OFF_W = 16,
  parameter int ID_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_opcode,
  input  logic [3:0]       in_src_field,
  input  logic [XLEN-1:0]  in_dst_val,
  input  logic [XLEN-1:0]  in_src_val,
  input  logic [XLEN-1:0]  in_imm,
  input  logic [OFF_W-1:0] in_offset,
  input  logic [PC_W-1:0]  in_pc,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_taken,
  output logic [PC_W-1:0]  out_next_pc,
  output logic             out_is_call,
  output logic [1:0]       out_call_kind,
  output logic [ID_W-1:0]  out_helper_id,
  output logic             out_is_exit,
  output logic             out_illegal
);
  brn_dec_t        dec;
  logic [XLEN-1:0] opb;
  logic            hit;
  logic            taken;
  logic [PC_W-1:0] next_pc;
  logic            accept;

  brn_decode #(.OP_W(8), .FLD_W(4)) u_dec (
    .opcode    (in_opcode),
    .src_field (in_src_field),
    .dec       (dec)
  );

  assign opb = dec.use_reg ? in_src_val : in_imm;

  brn_cond_eval #(.XLEN(XLEN)) u_cmp (
    .opa    (in_dst_val),
    .opb    (opb),
    .narrow (dec.narrow),
    .code   (dec.code),
    .hit    (hit)
  );

  assign taken = dec.is_ja
              || (dec.is_call && (dec.call_kind == CALL_LOCAL))
              || (dec.is_cond && hit);

  brn_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
    .pc      (in_pc),
    .offset  (in_offset),
    .taken   (taken),
    .next_pc (next_pc)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_taken     <= 1'b0;
      out_next_pc   <= '0;
      out_is_call   <= 1'b0;
      out_call_kind <= '0;
      out_helper_id <= '0;
      out_is_exit   <= 1'b0;
      out_illegal   <= 1'b0;
    end else begin
      if (accept) begin
        out_valid     <= 1'b1;
        out_taken     <= taken;
        out_next_pc   <= next_pc;
        out_is_call   <= dec.is_call;
        out_call_kind <= dec.is_call ? dec.call_kind : 2'd0;
        out_helper_id <= dec.is_call ? in_imm[ID_W-1:0] : '0;
        out_is_exit   <= dec.is_exit;
        out_illegal   <= dec.illegal;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_taken) && $stable(out_next_pc)
      && $stable(out_is_call) && $stable(out_is_exit) && $stable(out_illegal));

  // R2
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R12
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_taken && !out_is_call && !out_is_exit);

  // R10
  exit_fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_exit |-> !out_taken);

  // R12
  narrow_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_opcode[2:0] == 3'd6
      && (in_opcode[7:4] == 4'h0 || in_opcode[7:4] == 4'h8 || in_opcode[7:4] == 4'h9)
      |=> out_valid && out_illegal);

  // R9
  ja_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_opcode[7:4] == 4'h0 && in_opcode[2:0] == 3'd5 |=> out_valid && out_taken);
endmodule

// File: tb/brn_resolve_bench.sv
module brn_resolve_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = '0;
  logic [3:0]  in_src_field = '0;
  logic [63:0] in_dst_val = '0, in_src_val = '0, in_imm = '0;
  logic [15:0] in_offset = '0;
  logic [31:0] in_pc = '0;
  logic        out_valid, out_ready = 1'b1;
  logic        out_taken, out_is_call, out_is_exit, out_illegal;
  logic [31:0] out_next_pc, out_helper_id;
  logic [1:0]  out_call_kind;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  typedef struct {
    bit taken; bit [31:0] npc; bit call; bit [1:0] kind; bit [31:0] id;
    bit ext; bit ill; string tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  brn_resolve u_brn_resolve (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_src_field(in_src_field), .in_dst_val(in_dst_val),
    .in_src_val(in_src_val), .in_imm(in_imm), .in_offset(in_offset), .in_pc(in_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_taken(out_taken),
    .out_next_pc(out_next_pc), .out_is_call(out_is_call), .out_call_kind(out_call_kind),
    .out_helper_id(out_helper_id), .out_is_exit(out_is_exit), .out_illegal(out_illegal));

  function automatic exp_t model(bit [7:0] op, bit [3:0] fld, bit [63:0] d, bit [63:0] s,
                                 bit [63:0] im, bit [15:0] off, bit [31:0] pc, string tag);
    exp_t e;
    bit [63:0] b = op[3] ? s : im;
    bit n = (op[2:0] == 3'd6);
    bit [3:0] c = op[7:4];
    bit ok = (op[2:0] == 3'd5) || n;
    longint unsigned au = n ? longint'(d[31:0]) : d;
    longint unsigned bu = n ? longint'(b[31:0]) : b;
    longint as_ = n ? longint'(int'(d[31:0])) : longint'(d);
    longint bs_ = n ? longint'(int'(b[31:0])) : longint'(b);
    e = '{0, 0, 0, 0, 0, 0, 0, tag};
    if (!ok || c >= 4'he || (n && (c == 0 || c == 8 || c == 9)) || (c == 8 && fld > 2))
      e.ill = 1;
    else case (c)
      4'h0: e.taken = 1;
      4'h1: e.taken = (au == bu);
      4'h5: e.taken = (au != bu);
      4'h4: e.taken = ((au & bu) != 0);
      4'h2: e.taken = au > bu;
      4'h3: e.taken = au >= bu;
      4'ha: e.taken = au < bu;
      4'hb: e.taken = au <= bu;
      4'h6: e.taken = as_ > bs_;
      4'h7: e.taken = as_ >= bs_;
      4'hc: e.taken = as_ < bs_;
      4'hd: e.taken = as_ <= bs_;
      4'h8: begin e.call = 1; e.kind = fld[1:0]; e.taken = (fld == 1); e.id = im[31:0]; end
      4'h9: e.ext = 1;
      default: ;
    endcase
    e.npc = pc + 32'd1 + (e.taken ? {{16{off[15]}}, off} : 32'd0);
    return e;
  endfunction

  task automatic send(bit [7:0] op, bit [3:0] fld, bit [63:0] d, bit [63:0] s,
                      bit [63:0] im, bit [15:0] off, bit [31:0] pc, string tag);
    @(negedge clk);
    in_opcode = op; in_src_field = fld; in_dst_val = d; in_src_val = s;
    in_imm = im; in_offset = off; in_pc = pc; in_valid = 1'b1;
    sb.push_back(model(op, fld, d, s, im, off, pc, tag));
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // back-pressure pattern
  int rc = 0;
  initial forever begin
    @(negedge clk);
    rc++;
    out_ready = (rc > 400) ? ((rc % 7) != 2 && (rc % 5) != 4) : 1'b1;
  end

  // monitor / scoreboard
  initial begin
    bit held = 0;
    bit h_t, h_c, h_e, h_i; bit [31:0] h_pc;
    forever begin
      @(negedge clk); #3;
      if (rst_n) begin
        if (held) begin
          // R2 stall stability
          chk(out_valid && out_taken == h_t && out_next_pc == h_pc && out_is_call == h_c
              && out_is_exit == h_e && out_illegal == h_i, "R2", "stall hold",
              longint'(out_next_pc), longint'(h_pc));
          held = 0;
        end
        if (out_valid && out_ready) begin
          exp_t e;
          if (sb.size() == 0) chk(0, "R2", "unexpected result", 1, 0);
          else begin
            e = sb.pop_front();
            chk(out_illegal == e.ill, e.tag, "illegal", out_illegal, e.ill);
            chk(out_taken == e.taken, e.tag, "taken", out_taken, e.taken);
            chk(out_next_pc == e.npc, e.tag, "next_pc", out_next_pc, e.npc);
            chk(out_is_exit == e.ext, e.tag, "exit", out_is_exit, e.ext);
            chk(out_is_call == e.call, e.tag, "call", out_is_call, e.call);
            if (e.call) begin
              chk(out_call_kind == e.kind, e.tag, "call_kind", out_call_kind, e.kind);
              chk(out_helper_id == e.id, e.tag, "helper_id", out_helper_id, e.id);
            end
          end
        end else if (out_valid) begin
          held = 1; h_t = out_taken; h_pc = out_next_pc; h_c = out_is_call;
          h_e = out_is_exit; h_i = out_illegal;
        end
      end
    end
  end

  function automatic string sweep_tag(bit [7:0] op);
    bit [3:0] c = op[7:4];
    if (!(op[2:0] == 3'd5 || op[2:0] == 3'd6) || c >= 4'he) return "R12";
    if (op[2:0] == 3'd6 && (c == 0 || c == 8 || c == 9)) return "R12";
    case (c)
      4'h0: return "R9";
      4'h8: return "R11";
      4'h9: return "R10";
      4'h1, 4'h4, 4'h5: return "R7";
      4'h2, 4'h3, 4'ha, 4'hb: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && in_ready, "R1", "reset idle", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk); #3;
    chk(!out_valid && in_ready, "R1", "post-reset idle", {out_valid, in_ready}, 2'b01);

    // R3: low halves equal, upper differ
    send(8'h1d, 0, 64'h1_0000_0005, 64'h2_0000_0005, 0, 16'd4, 32'd100, "R3");
    send(8'h1e, 0, 64'h1_0000_0005, 64'h2_0000_0005, 0, 16'd4, 32'd100, "R3");
    send(8'h6e, 0, 64'h0000_0000_8000_0000, 64'd1, 0, 16'd2, 32'd7, "R3");
    send(8'h6d, 0, 64'h0000_0000_8000_0000, 64'd1, 0, 16'd2, 32'd7, "R3");
    // R4 operand select
    send(8'h15, 0, 64'd9, 64'd3, 64'd9, 16'd5, 32'd20, "R4");
    send(8'h1d, 0, 64'd9, 64'd3, 64'd9, 16'd5, 32'd20, "R4");
    // R5 / R6 all-ones vs one
    send(8'h2d, 0, '1, 64'd1, 0, 16'd3, 32'd0, "R5");
    send(8'h6d, 0, '1, 64'd1, 0, 16'd3, 32'd0, "R6");
    send(8'hcd, 0, '1, 64'd1, 0, 16'd3, 32'd0, "R6");
    send(8'hbd, 0, 64'd5, 64'd5, 0, 16'd3, 32'd0, "R5");
    // R7 set / eq / ne
    send(8'h4d, 0, 64'hF0, 64'h0F, 0, 16'd1, 32'd1, "R7");
    send(8'h45, 0, 64'hF0, 64'hFFFF_FFFF_FFFF_FF10, 64'hFFFF_FFFF_FFFF_FF10, 16'd1, 32'd1, "R7");
    // R8 wrap and negative displacement
    send(8'h05, 0, 0, 0, 0, 16'd0, 32'hFFFF_FFFF, "R8");
    send(8'h05, 0, 0, 0, 0, 16'hFFF5, 32'd10, "R8");
    send(8'h0d, 0, 0, 0, 0, 16'h8000, 32'h0001_0000, "R9");
    // R10 / R11
    send(8'h95, 0, 1, 2, 0, 16'd9, 32'd50, "R10");
    send(8'h85, 1, 0, 0, 64'h1234, 16'hFFFE, 32'd50, "R11");
    send(8'h85, 0, 0, 0, 64'hFFFF_FFFF_DEAD_BEEF, 16'd9, 32'd50, "R11");
    send(8'h85, 2, 0, 0, 64'h77, 16'd9, 32'd50, "R11");
    send(8'h85, 3, 0, 0, 64'h77, 16'd9, 32'd50, "R11");
    // R12
    send(8'h86, 1, 0, 0, 0, 16'd9, 32'd3, "R12");
    send(8'he5, 0, 0, 0, 0, 16'd9, 32'd3, "R12");

    // full opcode sweep with several operand sets
    for (int k = 0; k < 3; k++)
      for (int op = 0; op < 256; op++)
        send(8'(op), 4'(k), (k == 0) ? 64'hFFFF_FFFF_0000_0001 : 64'h8000_0000_0000_0000 + 64'(k),
             64'h0000_0001_8000_0000, 64'hFFFF_FFFF_FFFF_FFF0, 16'(op * 3 - 40), 32'(op * 17),
             sweep_tag(8'(op)));

    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    while (!done && cycles < 20000) begin @(posedge clk); cycles++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule